// File: doc/BRIEF.md
# Crosspoint I/O Cell

This block is one routable output cell in a programmable signal-crosspoint fabric. Four candidate sources reach it, one from each of four input pin groups. A dynamic select input picks one of them. When the cell is set to cascade, a second dynamic 4:1 stage instead picks among the local selector results of four neighbouring cells, so a group of cells can act as one 16:1 selector. The chosen bit passes through an input stage and then an output stage. Each stage is set on its own to pass the bit straight through, to hold it in a level-sensitive latch, or to hold it in an edge-triggered register.

The storage elements take their clock and clock-enable from a configurable source. The source is either one of a set of global lines or one of a set of lines derived from I/O pins. The clock-enable can also be ignored. A constant can override the pad data, so the cell can stand in for a jumper or DIP switch. The pad enable has configurable polarity, and it stays inactive until software marks the configuration as valid.

Static settings sit in four 8-bit configuration registers. They are written through a synchronous port: address, data and write strobe. An active-low asynchronous reset clears every setting to the safe default.

Top module: `xpt_io_cell`

## Requirements
- R1: Reset clears all configuration. After reset, `pad_oe_o` is 0, the cascade is off, no constant is forced, both stages are combinational, the valid flag is clear, and the clock-enable is ignored.
- R2: `mux_o` equals `src_i[sel_i]` at all times. Bit 0 of `src_i` is group A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: When cascade is on (address 1, bit 0), the data fed to the stages is `cas_i[cas_sel_i]` in place of the local selection. `mux_o` is not affected.
- R4: A stage mode code sits at address 0: bits 1:0 for the input stage and bits 3:2 for the output stage. Code 00 is combinational, and so is code 11. With both stages combinational, `pad_o` follows the routed data with no clock.
- R5: Register mode (code 10) captures on the rising edge of the selected clock. It holds across edges of clocks that are not selected. Two registered stages in series give two edges of delay.
- R6: Latch mode (code 01) is transparent while the selected clock is high and the enable is active. It holds while the clock is low.
- R7: When address 2, bit 6 is 1, the selected clock-enable gates both the register and the latch: if it is low, neither updates. The enable source is chosen by bits 4:3 (index) and bit 5 (1 = I/O-derived set, 0 = global set).
- R8: The stage clock is chosen by address 2: bits 1:0 give the index, and bit 2 picks the I/O-derived set (1) or the global set (0).
- R9: Once the configuration is valid, `pad_oe_o` equals `oe_i` XOR the enable-invert bit (address 1, bit 1).
- R10: `pad_oe_o` stays 0 while the valid flag (address 3, bit 0) is clear, whatever `oe_i` is.
- R11: When force is on (address 1, bit 2), `pad_o` equals the force value (address 1, bit 3), whatever the data is.
- R12: A write with `cfg_we_i` high takes effect at the rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| src_i | input | 4 | Group sources, bit 0 = A through bit 3 = D |
| sel_i | input | 2 | Dynamic local source select |
| cas_i | input | 4 | Local selector results of four neighbour cells |
| cas_sel_i | input | 2 | Dynamic cascade select |
| gclk_i | input | 4 | Global clock lines |
| gce_i | input | 4 | Global clock-enable lines |
| io_clk_i | input | 4 | Clock lines derived from I/O pins |
| io_ce_i | input | 4 | Clock-enable lines derived from I/O pins |
| oe_i | input | 1 | Raw output enable before polarity |
| mux_o | output | 1 | Local 4:1 result, for cascading into neighbours |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bench builds the cell with its default parameters: four source groups and four clock lines in each set. At that size every select value can be swept against every source pattern, for both the local and the cascade stage. The same size makes it possible to try all eight clock choices, each against competing edges from clocks that are not selected. It also puts every combination of valid flag, enable polarity and raw enable within reach, along with both force values. Register chains, latch transparency and enable gating from both enable sets are driven through explicit clock pulses, so the expected pad value is known at each step.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_REG   = 2'b10,
    MODE_ALT   = 2'b11
  } stage_mode_e;

  localparam int unsigned CFG_REGS   = 4;
  localparam int unsigned ADR_MODE   = 0;
  localparam int unsigned ADR_ROUTE  = 1;
  localparam int unsigned ADR_CLOCK  = 2;
  localparam int unsigned ADR_CTRL   = 3;

  localparam int unsigned RT_CAS     = 0;
  localparam int unsigned RT_OE_INV  = 1;
  localparam int unsigned RT_FRC_EN  = 2;
  localparam int unsigned RT_FRC_VAL = 3;
endpackage

// File: rtl/xpt_sel.sv
module xpt_sel #(
  parameter int unsigned N = 4,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  in_i,
  input  logic [SW-1:0] sel_i,
  output logic          out_o
);
  assign out_o = in_i[sel_i];
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NREG-1:0][DW-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_o[r] <= '0;
      else if (we_i && addr_i == AW'(r))    regs_o[r] <= wdata_i;
    end
  end
endmodule

// File: rtl/xpt_stage.sv
module xpt_stage
  import xpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_i,
  input  stage_mode_e mode_i,
  input  logic        d_i,
  output logic        q_o
);
  logic ff_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ff_q <= 1'b0;
    else if (ce_i) ff_q <= d_i;
  end

  always_latch begin
    if (!rst_ni)            lat_q = 1'b0;
    else if (clk_i && ce_i) lat_q = d_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_LATCH: q_o = lat_q;
      MODE_REG:   q_o = ff_q;
      default:    q_o = d_i;
    endcase
  end
endmodule

// File: rtl/xpt_io_cell.sv
module xpt_io_cell
  import xpt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned NUM_CLK = 4,
  parameter int unsigned CFG_DW  = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned CK_W   = $clog2(NUM_CLK),
  localparam int unsigned CFG_AW = $clog2(CFG_REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] cas_i,
  input  logic [SEL_W-1:0]   cas_sel_i,
  input  logic [NUM_CLK-1:0] gclk_i,
  input  logic [NUM_CLK-1:0] gce_i,
  input  logic [NUM_CLK-1:0] io_clk_i,
  input  logic [NUM_CLK-1:0] io_ce_i,
  input  logic               oe_i,
  output logic               mux_o,
  output logic               pad_o,
  output logic               pad_oe_o
);
  // clocking register field positions
  localparam int unsigned CK_IO  = CK_W;
  localparam int unsigned CE_LO  = CK_W + 1;
  localparam int unsigned CE_IO  = 2 * CK_W + 1;
  localparam int unsigned CE_USE = 2 * CK_W + 2;

  logic [CFG_REGS-1:0][CFG_DW-1:0] cfg;

  xpt_cfg_bank #(.NREG(CFG_REGS), .DW(CFG_DW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .regs_o  (cfg)
  );

  stage_mode_e in_mode, out_mode;
  logic cas_en, oe_inv, force_en, force_val, cfg_valid;
  logic [CK_W-1:0] clk_idx, ce_idx;
  logic clk_io, ce_io, ce_use;

  assign in_mode   = stage_mode_e'(cfg[ADR_MODE][1:0]);
  assign out_mode  = stage_mode_e'(cfg[ADR_MODE][3:2]);
  assign cas_en    = cfg[ADR_ROUTE][RT_CAS];
  assign oe_inv    = cfg[ADR_ROUTE][RT_OE_INV];
  assign force_en  = cfg[ADR_ROUTE][RT_FRC_EN];
  assign force_val = cfg[ADR_ROUTE][RT_FRC_VAL];
  assign clk_idx   = cfg[ADR_CLOCK][CK_W-1:0];
  assign clk_io    = cfg[ADR_CLOCK][CK_IO];
  assign ce_idx    = cfg[ADR_CLOCK][CE_LO +: CK_W];
  assign ce_io     = cfg[ADR_CLOCK][CE_IO];
  assign ce_use    = cfg[ADR_CLOCK][CE_USE];
  assign cfg_valid = cfg[ADR_CTRL][0];

  logic unused_cfg;
  assign unused_cfg = ^{cfg[ADR_MODE][CFG_DW-1:4], cfg[ADR_ROUTE][CFG_DW-1:4],
                        cfg[ADR_CLOCK][CFG_DW-1:CE_USE+1], cfg[ADR_CTRL][CFG_DW-1:1]};

  // dynamic data selection, two levels
  logic cas_pick, routed;

  xpt_sel #(.N(NUM_SRC)) u_sel_loc (.in_i(src_i), .sel_i(sel_i),     .out_o(mux_o));
  xpt_sel #(.N(NUM_SRC)) u_sel_cas (.in_i(cas_i), .sel_i(cas_sel_i), .out_o(cas_pick));

  assign routed = cas_en ? cas_pick : mux_o;

  // clock / clock-enable source selection: index 0 = clock, 1 = enable
  logic [1:0][NUM_CLK-1:0] g_lines, io_lines;
  logic [1:0][CK_W-1:0]    line_idx;
  logic [1:0]              line_io, line_pick;

  assign g_lines  = {gce_i, gclk_i};
  assign io_lines = {io_ce_i, io_clk_i};
  assign line_idx = {ce_idx, clk_idx};
  assign line_io  = {ce_io, clk_io};

  for (genvar k = 0; k < 2; k++) begin : g_src
    logic g_pick, io_pick;
    xpt_sel #(.N(NUM_CLK)) u_g  (.in_i(g_lines[k]),  .sel_i(line_idx[k]), .out_o(g_pick));
    xpt_sel #(.N(NUM_CLK)) u_io (.in_i(io_lines[k]), .sel_i(line_idx[k]), .out_o(io_pick));
    assign line_pick[k] = line_io[k] ? io_pick : g_pick;
  end

  logic stage_clk, stage_ce;
  assign stage_clk = line_pick[0];
  assign stage_ce  = !ce_use || line_pick[1];

  // input stage then output stage
  logic in_q, out_q;

  xpt_stage u_in (
    .clk_i(stage_clk), .rst_ni(rst_ni), .ce_i(stage_ce),
    .mode_i(in_mode), .d_i(routed), .q_o(in_q)
  );

  xpt_stage u_out (
    .clk_i(stage_clk), .rst_ni(rst_ni), .ce_i(stage_ce),
    .mode_i(out_mode), .d_i(in_q), .q_o(out_q)
  );

  assign pad_o    = force_en ? force_val : out_q;
  assign pad_oe_o = cfg_valid && (oe_i ^ oe_inv);
endmodule

// File: rtl/xpt_io_cell_chk.sv
module xpt_io_cell_chk
  import xpt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [SEL_W-1:0]   sel_i,
  input logic [NUM_SRC-1:0] cas_i,
  input logic [SEL_W-1:0]   cas_sel_i,
  input logic               oe_i,
  input logic               pad_o,
  input logic               pad_oe_o,
  input logic               cfg_valid,
  input logic               oe_inv,
  input logic               force_en,
  input logic               force_val,
  input logic               cas_en,
  input stage_mode_e        in_mode,
  input stage_mode_e        out_mode
);
  logic all_comb;
  assign all_comb = (in_mode == MODE_COMB || in_mode == MODE_ALT) &&
                    (out_mode == MODE_COMB || out_mode == MODE_ALT);

  a_r10_hiz_until_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid |-> !pad_oe_o);

  a_r9_oe_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid |-> pad_oe_o == (oe_i ^ oe_inv));

  a_r11_force_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en |-> pad_o == force_val);

  a_r4_comb_local_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_comb && !force_en && !cas_en) |-> pad_o == src_i[sel_i]);

  a_r3_comb_cascade_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_comb && !force_en && cas_en) |-> pad_o == cas_i[cas_sel_i]);
endmodule

bind xpt_io_cell xpt_io_cell_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/tb_xpt_io_cell.sv
module tb_xpt_io_cell;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000 * CLK_PERIOD;

  logic       clk_i = 0, rst_ni = 0, cfg_we_i = 0;
  logic [1:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [3:0] src_i = '0, cas_i = '0, gclk_i = '0, gce_i = '0, io_clk_i = '0, io_ce_i = '0;
  logic [1:0] sel_i = '0, cas_sel_i = '0;
  logic       oe_i = 0;
  logic       mux_o, pad_o, pad_oe_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xpt_io_cell dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic pulse(input bit io, input int idx);
    if (io) io_clk_i[idx] = 1; else gclk_i[idx] = 1;
    #3;
    if (io) io_clk_i[idx] = 0; else gclk_i[idx] = 0;
    #3;
  endtask

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev;
    oe_i = 1;
    #3;
    chk("R1 oe low in reset", pad_oe_o, 1'b0);
    chk("R1 pad low in reset", pad_o, 1'b0);
    #20 rst_ni = 1;
    @(negedge clk_i);
    chk("R10 oe held off before valid", pad_oe_o, 1'b0);

    // R2/R4: local select sweep, all stages combinational
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 16; p++) begin
        sel_i = 2'(s); src_i = 4'(p); #1;
        chk("R2 local select", mux_o, p[s]);
        chk("R4 comb pad", pad_o, p[s]);
      end
    wr(0, 8'h0F);  // both stages code 11
    src_i = 4'b0100; sel_i = 2; #1;
    chk("R4 code 11 comb", pad_o, 1'b1);

    // R3: cascade sweep
    wr(1, 8'h01);
    src_i = 4'b0000; sel_i = 0;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 16; p++) begin
        cas_sel_i = 2'(c); cas_i = 4'(p); #1;
        chk("R3 cascade pick", pad_o, p[c]);
        chk("R3 mux_o stays local", mux_o, 1'b0);
      end
    wr(1, 8'h00);

    // R9/R10: enable sweep
    for (int v = 0; v < 2; v++)
      for (int iv = 0; iv < 2; iv++) begin
        wr(3, 8'(v)); wr(1, 8'(iv << 1));
        for (int o = 0; o < 2; o++) begin
          oe_i = 1'(o); #1;
          chk(v ? "R9 oe polarity" : "R10 oe off until valid", pad_oe_o, 1'(v & (o ^ iv)));
        end
      end
    wr(1, 8'h00);

    // R11: force
    sel_i = 0;
    for (int f = 0; f < 2; f++) begin
      wr(1, 8'(4 | (f << 3)));
      for (int d = 0; d < 2; d++) begin
        src_i = 4'(d); #1;
        chk("R11 forced constant", pad_o, 1'(f));
      end
    end
    wr(1, 8'h00);

    // R5/R8/R12: input register, every clock source
    wr(0, 8'h02);
    sel_i = 0;
    for (int io = 0; io < 2; io++)
      for (int k = 0; k < 4; k++) begin
        wr(2, 8'((io << 2) | k));
        src_i = 4'd1; pulse(io[0], k);
        chk("R8 selected clock captures", pad_o, 1'b1);
        src_i = 4'd0; #1;
        chk("R5 register holds without edge", pad_o, 1'b1);
        pulse(io[0], (k + 1) % 4);
        chk("R8 other index ignored", pad_o, 1'b1);
        pulse(!io[0], k);
        chk("R8 other set ignored", pad_o, 1'b1);
        pulse(io[0], k);
        chk("R5 rising edge capture", pad_o, 1'b0);
      end

    // R5: two registered stages
    wr(2, 8'h00); wr(0, 8'h0A);
    src_i = 0; pulse(0, 0); pulse(0, 0);
    src_i = 1; pulse(0, 0);
    chk("R5 two-stage first edge", pad_o, 1'b0);
    pulse(0, 0);
    chk("R5 two-stage second edge", pad_o, 1'b1);

    // R6: latch input stage
    wr(0, 8'h01);
    gclk_i[0] = 1; src_i = 0; #2;
    chk("R6 transparent low", pad_o, 1'b0);
    src_i = 1; #2;
    chk("R6 transparent high", pad_o, 1'b1);
    gclk_i[0] = 0; #2;
    src_i = 0; #2;
    chk("R6 hold while clock low", pad_o, 1'b1);

    // R7: enable gating, global enable line 2
    wr(2, 8'h50);
    gce_i = 0;
    gclk_i[0] = 1; #2;
    chk("R7 latch blocked by enable", pad_o, 1'b1);
    gclk_i[0] = 0; #2;
    wr(0, 8'h02);
    prev = pad_o;
    src_i = {3'b0, ~prev}; pulse(0, 0);
    chk("R7 register blocked by enable", pad_o, prev);
    gce_i[2] = 1; pulse(0, 0);
    chk("R7 register with enable", pad_o, ~prev);
    // I/O-derived enable line 1
    wr(2, 8'h68);
    io_ce_i = 0; src_i = {3'b0, prev}; pulse(0, 0);
    chk("R7 io enable low blocks", pad_o, ~prev);
    io_ce_i[1] = 1; pulse(0, 0);
    chk("R7 io enable high passes", pad_o, prev);

    // R12: write timing
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 1; cfg_wdata_i = 8'h04;
    #1;
    chk("R12 no effect before edge", pad_o, prev);
    @(negedge clk_i);
    cfg_we_i = 0;
    chk("R12 effect after edge", pad_o, 1'b0);

    // R1: mid-run reset clears everything
    wr(1, 8'h0D); wr(3, 8'h01); wr(1, 8'h0F);
    oe_i = 0; sel_i = 3; src_i = 4'b1000; cas_i = 0;
    rst_ni = 0; #2;
    chk("R1 oe cleared", pad_oe_o, 1'b0);
    chk("R1 force and cascade cleared", pad_o, 1'b1);
    src_i = 4'b0000; #1;
    chk("R1 combinational after reset", pad_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 valid cleared", pad_oe_o, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule